// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block is the command front end of an on-chip nonvolatile memory controller. Software writes a 16-bit control word over a simple peripheral bus. The word carries an 8-bit execution key in bits 15:8 and a 7-bit command code in bits 6:0. Bit 7 is ignored. The internal command register resets to 0x0000.

The block checks the key, the busy state and the target of each command. It refuses bad requests by raising an error flag. Memory operations go to a back end over a one-cycle request strobe, and the back end answers with an acknowledge. Commands that change protection state are applied inside the block. A command never starts while a system-bus memory access or the back end is busy.

The block also holds the protection state:
- one lock bit for each address region;
- a chip-erase lock;
- a boot-protect-disable bit;
- two hard locks that stay set until a hardware reset.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset, `ready` is 1. All three flags, `be_req`, `region_lock`, `ce_blocked`, `boot_prot_off` and both hard locks are 0.
- R2: A write whose key field (bits 15:8) is not 0xA5 is discarded. It sets `flag_prog_err` in the cycle after the write, and `ready` stays 1.
- R3: A write made while `ready` is 0 sets `flag_prog_err` and is discarded. The command already in progress continues.
- R4: An accepted command executes at the first clock edge after the write at which both `sys_busy` and `be_busy` are 0. A memory command raises `be_req` for exactly one cycle after that edge.
- R5: Codes 0x00, 0x01, 0x03, 0x04 and 0x15 are memory commands. They drive `be_op` as 0, 1, 3, 4 and 5 respectively, and drive `be_addr` with the address latched at the write.
- R6: `flag_done` rises in the cycle after the back end acknowledges a memory command (`be_ack` high while it is outstanding). After the same edge, `ready` returns to 1.
- R7: The following set `flag_prog_err` and issue no request: code 0x00 when `nvm_user_page` is 0, and codes 0x01 or 0x03 when it is 1.
- R8: The region is `nvm_addr[ADDR_W-1 -: log2(NREG)]`. Code 0x11 sets that region's bit in `region_lock` and code 0x12 clears it. Codes 0x01, 0x03 and 0x04 outside the user page that target a locked region do three things: they set `flag_lock_err`, they issue no request, and they leave `flag_done` low.
- R9: Code 0x18 sets and 0x19 clears the chip-erase lock. Code 0x1C sets `ce_hard_lock`, and `ce_blocked` then stays 1 until reset.
- R10: Code 0x1A sets and 0x1B clears boot-protect disable. Code 0x1D sets `bp_hard_lock`, which forces `boot_prot_off` to 0 until reset.
- R11: The reserved codes set `flag_prog_err` and start nothing. These are 0x02, 0x05 to 0x0F, 0x1E to 0x2F, 0x33 and 0x38 to 0x7F.
- R12: Code 0x10 pulses `cfg_rst` for one cycle and sets `flag_done`. Region locks and the other protection state are kept.
- R13: The bits of `flag_clr` clear the flags: bit 0 clears done, bit 1 clears programming error and bit 2 clears lock error. When a set and a clear of the same flag happen in the same cycle, the set wins.
- R14: The remaining valid codes (0x13, 0x14, 0x16, 0x17, 0x30 to 0x32 and 0x34 to 0x37) set `flag_done` and change no state held in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control-word write strobe |
| ctrl_wdata | input | 16 | Control word: key in bits 15:8, code in bits 6:0 |
| sys_busy | input | 1 | A system-bus memory access is active |
| nvm_addr | input | ADDR_W | Address register value |
| nvm_user_page | input | 1 | Address lies in the user page |
| flag_clr | input | 3 | Flag clear bits (done, prog error, lock error) |
| be_busy | input | 1 | Back end is busy |
| be_ack | input | 1 | Back end has finished the outstanding operation |
| be_req | output | 1 | One-cycle request to the back end |
| be_op | output | 3 | Back-end operation code |
| be_addr | output | ADDR_W | Back-end target address |
| ready | output | 1 | No command in progress |
| flag_done | output | 1 | Command-complete flag |
| flag_prog_err | output | 1 | Programming-error flag |
| flag_lock_err | output | 1 | Locked-region error flag |
| region_lock | output | NREG | Lock bit per region |
| ce_blocked | output | 1 | Chip erase unavailable |
| boot_prot_off | output | 1 | Boot protection disabled |
| ce_hard_lock | output | 1 | Chip-erase hard lock |
| bp_hard_lock | output | 1 | Boot-protect hard lock |
| cfg_rst | output | 1 | Configuration reset pulse |

## Verification
Each result has a fixed due time:
- A key or busy error is visible one cycle after the write edge.
- A command with idle buses executes on the next edge. From that edge, three results appear together: the request, the other flags and the protection state.
- `flag_done` for a memory command follows the acknowledge edge by one cycle.

The bench drives inputs and samples outputs on the falling edge. It counts exactly these edges, so every check lands in the first cycle its result may appear. When `sys_busy` or `be_busy` is held, the bench confirms that no request appears on the edges in between.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    localparam logic [7:0] EXEC_KEY = 8'hA5;

    typedef enum logic [2:0] {
        BE_ERASE_PAGE  = 3'd0,
        BE_ERASE_BLOCK = 3'd1,
        BE_WRITE_PAGE  = 3'd3,
        BE_WRITE_QUAD  = 3'd4,
        BE_CLR_BUFFER  = 3'd5
    } be_op_e;

    typedef enum logic [1:0] {
        CLS_RSVD,
        CLS_MEM,
        CLS_PROT,
        CLS_SWRST
    } cmd_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_WAIT
    } seq_st_e;

    typedef struct packed {
        cmd_cls_e cls;
        be_op_e   op;
        logic     need_user;
        logic     forbid_user;
        logic     lock_chk;
    } cmd_dec_t;

    // protection command codes
    localparam logic [6:0] C_SWRST   = 7'h10;
    localparam logic [6:0] C_LOCK    = 7'h11;
    localparam logic [6:0] C_UNLOCK  = 7'h12;
    localparam logic [6:0] C_CE_SET  = 7'h18;
    localparam logic [6:0] C_CE_CLR  = 7'h19;
    localparam logic [6:0] C_BP_SET  = 7'h1A;
    localparam logic [6:0] C_BP_CLR  = 7'h1B;
    localparam logic [6:0] C_CE_HARD = 7'h1C;
    localparam logic [6:0] C_BP_HARD = 7'h1D;

    function automatic cmd_dec_t decode_cmd(input logic [6:0] code);
        cmd_dec_t d;
        d = '{cls: CLS_RSVD, op: BE_ERASE_PAGE, need_user: 1'b0,
              forbid_user: 1'b0, lock_chk: 1'b0};
        case (code)
            7'h00: begin d.cls = CLS_MEM; d.op = BE_ERASE_PAGE;  d.need_user = 1'b1; end
            7'h01: begin d.cls = CLS_MEM; d.op = BE_ERASE_BLOCK; d.forbid_user = 1'b1; d.lock_chk = 1'b1; end
            7'h03: begin d.cls = CLS_MEM; d.op = BE_WRITE_PAGE;  d.forbid_user = 1'b1; d.lock_chk = 1'b1; end
            7'h04: begin d.cls = CLS_MEM; d.op = BE_WRITE_QUAD;  d.lock_chk = 1'b1; end
            7'h15: begin d.cls = CLS_MEM; d.op = BE_CLR_BUFFER; end
            C_SWRST: d.cls = CLS_SWRST;
            7'h11, 7'h12, 7'h13, 7'h14, 7'h16, 7'h17, 7'h18, 7'h19,
            7'h1A, 7'h1B, 7'h1C, 7'h1D, 7'h30, 7'h31, 7'h32, 7'h34,
            7'h35, 7'h36, 7'h37: d.cls = CLS_PROT;
            default: d.cls = CLS_RSVD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/nvm_irq_flags.sv
module nvm_irq_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_done,
    input  logic       set_perr,
    input  logic       set_lerr,
    input  logic [2:0] clr,
    output logic       done,
    output logic       perr,
    output logic       lerr
);
    // a set in the same cycle as a clear takes precedence
    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            perr <= 1'b0;
            lerr <= 1'b0;
        end else begin
            done <= set_done | (done & ~clr[0]);
            perr <= set_perr | (perr & ~clr[1]);
            lerr <= set_lerr | (lerr & ~clr[2]);
        end
    end
endmodule

// File: rtl/nvm_prot_state.sv
module nvm_prot_state
    import nvm_cmd_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_go,
    input  logic [6:0]      op_code,
    input  logic [RW-1:0]   op_region,
    output logic [NREG-1:0] region_lock,
    output logic            ce_blocked,
    output logic            boot_prot_off,
    output logic            ce_hard,
    output logic            bp_hard
);
    logic ce_lock_q;
    logic bp_dis_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            region_lock <= '0;
            ce_lock_q   <= 1'b0;
            bp_dis_q    <= 1'b0;
            ce_hard     <= 1'b0;
            bp_hard     <= 1'b0;
        end else if (op_go) begin
            case (op_code)
                C_LOCK:    region_lock[op_region] <= 1'b1;
                C_UNLOCK:  region_lock[op_region] <= 1'b0;
                C_CE_SET:  ce_lock_q <= 1'b1;
                C_CE_CLR:  ce_lock_q <= 1'b0;
                C_BP_SET:  bp_dis_q  <= 1'b1;
                C_BP_CLR:  bp_dis_q  <= 1'b0;
                C_CE_HARD: ce_hard   <= 1'b1;
                C_BP_HARD: bp_hard   <= 1'b1;
                default:   ;
            endcase
        end
    end

    assign ce_blocked    = ce_lock_q | ce_hard;
    assign boot_prot_off = bp_dis_q & ~bp_hard;
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
    import nvm_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NREG   = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [15:0]       wdata,
    input  logic              sys_busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic              user_page,
    input  logic              be_busy,
    input  logic              be_ack,
    input  logic [NREG-1:0]   region_lock,
    output logic              be_req,
    output logic [2:0]        be_op,
    output logic [ADDR_W-1:0] be_addr,
    output logic              ready,
    output logic              set_done,
    output logic              set_perr,
    output logic              set_lerr,
    output logic              prot_go,
    output logic [6:0]        prot_code,
    output logic [RW-1:0]     prot_region,
    output logic              cfg_rst
);
    seq_st_e           st_q, st_d;
    logic [6:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              user_q;
    cmd_dec_t          dec;
    logic              key_ok, wr_err, exec, issue, swrst_go, perr_x;
    logic [RW-1:0]     rgn;
    logic              unused_bit7;

    assign unused_bit7 = wdata[7];
    assign key_ok  = (wdata[15:8] == EXEC_KEY);
    assign wr_err  = wr && (!key_ok || st_q != ST_IDLE);
    assign exec    = (st_q == ST_PEND) && !sys_busy && !be_busy;
    assign dec     = decode_cmd(cmd_q);
    assign rgn     = addr_q[ADDR_W-1 -: RW];

    always_comb begin
        perr_x   = 1'b0;
        set_lerr = 1'b0;
        set_done = 1'b0;
        issue    = 1'b0;
        prot_go  = 1'b0;
        swrst_go = 1'b0;
        if (exec) begin
            case (dec.cls)
                CLS_RSVD: perr_x = 1'b1;
                CLS_MEM: begin
                    if ((dec.need_user && !user_q) || (dec.forbid_user && user_q))
                        perr_x = 1'b1;
                    else if (dec.lock_chk && !user_q && region_lock[rgn])
                        set_lerr = 1'b1;
                    else
                        issue = 1'b1;
                end
                CLS_PROT: begin
                    prot_go  = 1'b1;
                    set_done = 1'b1;
                end
                default: begin
                    swrst_go = 1'b1;
                    set_done = 1'b1;
                end
            endcase
        end
        if (st_q == ST_WAIT && be_ack)
            set_done = 1'b1;
    end

    assign set_perr = perr_x | wr_err;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (wr && key_ok) st_d = ST_PEND;
            ST_PEND: if (exec) st_d = issue ? ST_WAIT : ST_IDLE;
            ST_WAIT: if (be_ack) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cmd_q   <= '0;
            addr_q  <= '0;
            user_q  <= 1'b0;
            be_req  <= 1'b0;
            be_op   <= '0;
            be_addr <= '0;
            cfg_rst <= 1'b0;
        end else begin
            st_q    <= st_d;
            be_req  <= issue;
            cfg_rst <= swrst_go;
            if (st_q == ST_IDLE && wr && key_ok) begin
                cmd_q  <= wdata[6:0];
                addr_q <= addr;
                user_q <= user_page;
            end else if (swrst_go) begin
                cmd_q <= '0;
            end
            if (issue) begin
                be_op   <= dec.op;
                be_addr <= addr_q;
            end
        end
    end

    assign ready       = (st_q == ST_IDLE);
    assign prot_code   = cmd_q;
    assign prot_region = rgn;
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NREG   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [15:0]       ctrl_wdata,
    input  logic              sys_busy,
    input  logic [ADDR_W-1:0] nvm_addr,
    input  logic              nvm_user_page,
    input  logic [2:0]        flag_clr,
    input  logic              be_busy,
    input  logic              be_ack,
    output logic              be_req,
    output logic [2:0]        be_op,
    output logic [ADDR_W-1:0] be_addr,
    output logic              ready,
    output logic              flag_done,
    output logic              flag_prog_err,
    output logic              flag_lock_err,
    output logic [NREG-1:0]   region_lock,
    output logic              ce_blocked,
    output logic              boot_prot_off,
    output logic              ce_hard_lock,
    output logic              bp_hard_lock,
    output logic              cfg_rst
);
    localparam int RW = $clog2(NREG);

    logic          s_done, s_perr, s_lerr, p_go;
    logic [6:0]    p_code;
    logic [RW-1:0] p_rgn;

    nvm_cmd_seq #(.ADDR_W(ADDR_W), .NREG(NREG)) i_seq (
        .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(ctrl_wdata),
        .sys_busy(sys_busy), .addr(nvm_addr), .user_page(nvm_user_page),
        .be_busy(be_busy), .be_ack(be_ack), .region_lock(region_lock),
        .be_req(be_req), .be_op(be_op), .be_addr(be_addr), .ready(ready),
        .set_done(s_done), .set_perr(s_perr), .set_lerr(s_lerr),
        .prot_go(p_go), .prot_code(p_code), .prot_region(p_rgn),
        .cfg_rst(cfg_rst)
    );

    nvm_prot_state #(.NREG(NREG)) i_prot (
        .clk(clk), .rst(rst), .op_go(p_go), .op_code(p_code),
        .op_region(p_rgn), .region_lock(region_lock),
        .ce_blocked(ce_blocked), .boot_prot_off(boot_prot_off),
        .ce_hard(ce_hard_lock), .bp_hard(bp_hard_lock)
    );

    nvm_irq_flags i_flags (
        .clk(clk), .rst(rst), .set_done(s_done), .set_perr(s_perr),
        .set_lerr(s_lerr), .clr(flag_clr), .done(flag_done),
        .perr(flag_prog_err), .lerr(flag_lock_err)
    );
endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctrl_wr,
    input logic [15:0] ctrl_wdata,
    input logic        sys_busy,
    input logic        be_busy,
    input logic        be_req,
    input logic        ready,
    input logic        flag_done,
    input logic        flag_prog_err,
    input logic        flag_lock_err,
    input logic        ce_blocked,
    input logic        boot_prot_off,
    input logic        ce_hard_lock,
    input logic        bp_hard_lock
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ready && !be_req && !flag_done && !flag_prog_err && !flag_lock_err));

    a_r2_bad_key: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_wdata[15:8] != 8'hA5) |=> flag_prog_err);

    a_r3_busy_write: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ready) |=> flag_prog_err);

    a_r4_defer: assert property (@(posedge clk) disable iff (rst)
        be_req |-> $past(!sys_busy && !be_busy));

    a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
        be_req |=> !be_req);

    a_r8_lock_no_req: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_lock_err) |-> !be_req);

    a_r9_ce_hard: assert property (@(posedge clk) disable iff (rst)
        ce_hard_lock |-> ce_blocked);

    a_r9_ce_hard_sticky: assert property (@(posedge clk) disable iff (rst)
        ce_hard_lock |=> ce_hard_lock);

    a_r10_bp_hard: assert property (@(posedge clk) disable iff (rst)
        bp_hard_lock |-> !boot_prot_off);
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .sys_busy(sys_busy), .be_busy(be_busy), .be_req(be_req), .ready(ready),
    .flag_done(flag_done), .flag_prog_err(flag_prog_err),
    .flag_lock_err(flag_lock_err), .ce_blocked(ce_blocked),
    .boot_prot_off(boot_prot_off), .ce_hard_lock(ce_hard_lock),
    .bp_hard_lock(bp_hard_lock)
);

// File: tb/test_nvm_cmd_ctrl.sv
`timescale 1ns/1ps
module test_nvm_cmd_ctrl;
    localparam int ADDR_W = 20;
    localparam int NREG   = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctrl_wr = 1'b0;
    logic [15:0]       ctrl_wdata = '0;
    logic              sys_busy = 1'b0;
    logic [ADDR_W-1:0] nvm_addr = '0;
    logic              nvm_user_page = 1'b0;
    logic [2:0]        flag_clr = '0;
    logic              be_busy = 1'b0;
    logic              be_ack = 1'b0;
    logic              be_req;
    logic [2:0]        be_op;
    logic [ADDR_W-1:0] be_addr;
    logic              ready, flag_done, flag_prog_err, flag_lock_err;
    logic [NREG-1:0]   region_lock;
    logic              ce_blocked, boot_prot_off, ce_hard_lock, bp_hard_lock, cfg_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nvm_cmd_ctrl #(.ADDR_W(ADDR_W), .NREG(NREG)) i_nvm_cmd_ctrl (.*);

    // outcome: 0 done, 1 prog error, 2 lock error, 3 back-end request
    typedef struct packed {
        logic [6:0] code;
        logic       user;
        logic [4:0] rgn;
        logic [1:0] res;
        logic [2:0] op;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{7'h15, 1'b0, 5'd0, 2'd3, 3'd5},   // R5 clear buffer
        '{7'h01, 1'b0, 5'd3, 2'd3, 3'd1},   // R5 erase block
        '{7'h11, 1'b0, 5'd3, 2'd0, 3'd0},   // R8 lock region 3
        '{7'h01, 1'b0, 5'd3, 2'd2, 3'd0},   // R8 locked erase
        '{7'h04, 1'b0, 5'd3, 2'd2, 3'd0},   // R8 locked quad write
        '{7'h03, 1'b0, 5'd4, 2'd3, 3'd3},   // R5 write page other region
        '{7'h12, 1'b0, 5'd3, 2'd0, 3'd0},   // R8 unlock region 3
        '{7'h03, 1'b0, 5'd3, 2'd3, 3'd3},   // R8 unlocked write
        '{7'h00, 1'b1, 5'd0, 2'd3, 3'd0},   // R5 erase page user
        '{7'h00, 1'b0, 5'd0, 2'd1, 3'd0},   // R7 erase page outside user
        '{7'h01, 1'b1, 5'd0, 2'd1, 3'd0},   // R7 erase block user
        '{7'h03, 1'b1, 5'd0, 2'd1, 3'd0},   // R7 write page user
        '{7'h02, 1'b0, 5'd0, 2'd1, 3'd0},   // R11
        '{7'h0F, 1'b0, 5'd0, 2'd1, 3'd0},   // R11
        '{7'h2A, 1'b0, 5'd0, 2'd1, 3'd0},   // R11
        '{7'h33, 1'b0, 5'd0, 2'd1, 3'd0},   // R11
        '{7'h7F, 1'b0, 5'd0, 2'd1, 3'd0},   // R11
        '{7'h13, 1'b0, 5'd0, 2'd0, 3'd0},   // R14
        '{7'h36, 1'b0, 5'd0, 2'd0, 3'd0},   // R14
        '{7'h04, 1'b1, 5'd9, 2'd3, 3'd4}    // R5 quad write user
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_flags();
        flag_clr = 3'b111;
        tick();
        flag_clr = 3'b000;
        tick();
    endtask

    // returns at the falling edge after the write edge
    task automatic write_cmd(input logic [6:0] code, input logic [7:0] key,
                             input logic [4:0] rgn, input logic user);
        ctrl_wr       = 1'b1;
        ctrl_wdata    = {key, 1'b0, code};
        nvm_addr      = {rgn, 15'h0123};
        nvm_user_page = user;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic ack_backend();
        be_ack = 1'b1;
        tick();
        be_ack = 1'b0;
    endtask

    task automatic run_local(input logic [6:0] code);
        clear_flags();
        write_cmd(code, 8'hA5, 5'd0, 1'b0);
        tick();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(ready == 1'b1, "R1", "ready", ready, 1);
        chk({flag_done, flag_prog_err, flag_lock_err} == 3'b000, "R1", "flags",
            {flag_done, flag_prog_err, flag_lock_err}, 0);
        chk(be_req == 1'b0 && region_lock == '0, "R1", "req/locks", region_lock, 0);
        chk({ce_blocked, boot_prot_off, ce_hard_lock, bp_hard_lock} == 4'b0, "R1",
            "protection", {ce_blocked, boot_prot_off, ce_hard_lock, bp_hard_lock}, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            clear_flags();
            write_cmd(VECS[i].code, 8'hA5, VECS[i].rgn, VECS[i].user);
            tick();
            chk(be_req == (VECS[i].res == 2'd3), "R4", $sformatf("vec%0d be_req", i),
                be_req, VECS[i].res == 2'd3);
            chk(flag_prog_err == (VECS[i].res == 2'd1), "R7/R11",
                $sformatf("vec%0d prog_err", i), flag_prog_err, VECS[i].res == 2'd1);
            chk(flag_lock_err == (VECS[i].res == 2'd2), "R8",
                $sformatf("vec%0d lock_err", i), flag_lock_err, VECS[i].res == 2'd2);
            if (VECS[i].res == 2'd0)
                chk(flag_done == 1'b1, "R14", $sformatf("vec%0d done", i), flag_done, 1);
            if (VECS[i].res == 2'd2)
                chk(flag_done == 1'b0, "R8", $sformatf("vec%0d no done", i), flag_done, 0);
            if (VECS[i].code == 7'h11 || VECS[i].code == 7'h12)
                chk(region_lock[VECS[i].rgn] == (VECS[i].code == 7'h11), "R8",
                    $sformatf("vec%0d lock bit", i), region_lock[VECS[i].rgn],
                    VECS[i].code == 7'h11);
            if (VECS[i].res == 2'd3) begin
                chk(be_op == VECS[i].op, "R5", $sformatf("vec%0d be_op", i), be_op, VECS[i].op);
                chk(be_addr == {VECS[i].rgn, 15'h0123}, "R5", $sformatf("vec%0d be_addr", i),
                    be_addr, {VECS[i].rgn, 15'h0123});
                chk(flag_done == 1'b0 && ready == 1'b0, "R6", "done before ack",
                    {flag_done, ready}, 0);
                ack_backend();
                chk(flag_done == 1'b1 && ready == 1'b1, "R6", "done after ack",
                    {flag_done, ready}, 3);
            end
        end
        chk(region_lock == '0, "R8", "all regions unlocked", region_lock, 0);

        // R2 bad key, with R13 clear in the same cycle
        clear_flags();
        flag_clr = 3'b010;
        write_cmd(7'h15, 8'h5A, 5'd0, 1'b0);
        flag_clr = 3'b000;
        chk(flag_prog_err == 1'b1, "R13", "set beats clear", flag_prog_err, 1);
        chk(ready == 1'b1, "R2", "ready after bad key", ready, 1);
        tick();
        chk(be_req == 1'b0, "R2", "no request after bad key", be_req, 0);
        clear_flags();
        chk(flag_prog_err == 1'b0, "R13", "cleared", flag_prog_err, 0);

        // R3 write while busy
        write_cmd(7'h01, 8'hA5, 5'd5, 1'b0);
        tick();
        chk(be_req == 1'b1, "R3", "first request", be_req, 1);
        write_cmd(7'h15, 8'hA5, 5'd0, 1'b0);
        chk(flag_prog_err == 1'b1, "R3", "busy write error", flag_prog_err, 1);
        chk(ready == 1'b0 && be_req == 1'b0, "R3", "still busy", {ready, be_req}, 0);
        ack_backend();
        chk(flag_done == 1'b1 && ready == 1'b1, "R3", "first completes", {flag_done, ready}, 3);
        tick();
        chk(be_req == 1'b0, "R3", "discarded write not run", be_req, 0);

        // R4 defer on system bus and on back end busy
        clear_flags();
        sys_busy = 1'b1;
        write_cmd(7'h15, 8'hA5, 5'd0, 1'b0);
        tick();
        chk(be_req == 1'b0, "R4", "held by system bus", be_req, 0);
        tick();
        chk(be_req == 1'b0, "R4", "still held", be_req, 0);
        sys_busy = 1'b0;
        be_busy  = 1'b1;
        tick();
        chk(be_req == 1'b0, "R4", "held by back end", be_req, 0);
        be_busy = 1'b0;
        tick();
        chk(be_req == 1'b1 && be_op == 3'd5, "R4", "runs when idle", {be_req, be_op}, 4'hD);
        tick();
        chk(be_req == 1'b0, "R4", "single-cycle request", be_req, 0);
        ack_backend();
        chk(flag_done == 1'b1, "R6", "deferred done", flag_done, 1);

        // R9 chip-erase lock and hard lock
        run_local(7'h18);
        chk(ce_blocked == 1'b1, "R9", "ce lock set", ce_blocked, 1);
        run_local(7'h19);
        chk(ce_blocked == 1'b0, "R9", "ce lock cleared", ce_blocked, 0);
        run_local(7'h1C);
        chk(ce_blocked && ce_hard_lock, "R9", "hard lock", {ce_blocked, ce_hard_lock}, 3);
        run_local(7'h19);
        chk(ce_blocked == 1'b1, "R9", "hard lock holds", ce_blocked, 1);

        // R10 boot protect disable and hard lock
        run_local(7'h1A);
        chk(boot_prot_off == 1'b1, "R10", "bp disable set", boot_prot_off, 1);
        run_local(7'h1B);
        chk(boot_prot_off == 1'b0, "R10", "bp disable cleared", boot_prot_off, 0);
        run_local(7'h1A);
        run_local(7'h1D);
        chk(boot_prot_off == 1'b0 && bp_hard_lock, "R10", "hard lock forces off",
            {boot_prot_off, bp_hard_lock}, 1);
        run_local(7'h1A);
        chk(boot_prot_off == 1'b0, "R10", "set ignored under hard lock", boot_prot_off, 0);

        // R12 software reset keeps protection
        clear_flags();
        write_cmd(7'h11, 8'hA5, 5'd7, 1'b0);
        tick();
        clear_flags();
        write_cmd(7'h10, 8'hA5, 5'd0, 1'b0);
        tick();
        chk(cfg_rst == 1'b1 && flag_done == 1'b1, "R12", "swrst pulse and done",
            {cfg_rst, flag_done}, 3);
        tick();
        chk(cfg_rst == 1'b0, "R12", "pulse one cycle", cfg_rst, 0);
        chk(region_lock[7] == 1'b1 && ce_hard_lock, "R12", "state kept",
            {region_lock[7], ce_hard_lock}, 3);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule